// File: doc/BRIEF.md
# TLB Demap Command Decoder

This block sits between the store path and a translation lookaside buffer. A store to the demap space arrives with its address. The block decodes that address into one invalidation command for the TLB. Two separate address fields drive the decode: one names the operation and one names the context to use. The partition ID comes from the current partition register. The context ID comes from the primary context register, the secondary context register, or the constant zero of the nucleus context.

The command is issued in the cycle after the request, as a single-cycle pulse. It carries the kind of invalidation, the page address, the real-address flag, the partition ID and the context ID. Some context codes mark a request as ignored. An ignored request drops a page or context invalidation, but a partition-wide invalidation is still issued. The instruction side and the data side read context code 1 differently. The reserved operation code raises a single-cycle error pulse and issues no command.

Top module: `demap_decoder`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `cmd_valid`, `cmd_err` and every command data output are zero, whatever the request inputs are.
- R2: A request whose operation field `req_addr[7:6]` is 0, 1 or 2 and which is not dropped raises `cmd_valid` for exactly the next cycle. `cmd_kind` is then 0 (page), 1 (context) or 2 (partition-wide), and it equals the operation field.
- R3: Context field `req_addr[5:4]` = 0 selects `ctx_primary`, and code 3 selects context zero, on both sides.
- R4: Context code 1 selects `ctx_secondary` when `side_is_data` is 1. It marks the request as ignored when `side_is_data` is 0.
- R5: Context code 2 marks the request as ignored on both sides.
- R6: An ignored page or context request produces neither `cmd_valid` nor `cmd_err` in the next cycle.
- R7: A partition-wide request (operation 2) is issued whatever its context code is, and its `cmd_ctx` is zero.
- R8: For a page command, `cmd_page` equals `req_addr[63:13]` and `cmd_real` equals `req_addr[9]`. For context and partition-wide commands both are zero. The address bits 12:10, 8 and 3:0 have no effect.
- R9: `cmd_part` of every command equals `part_id` as sampled with the request.
- R10: Operation code 3 raises `cmd_err` for exactly the next cycle and issues no command, whatever the context code and side are.
- R11: In any cycle with `cmd_valid` low, `cmd_kind`, `cmd_page`, `cmd_real`, `cmd_part` and `cmd_ctx` are all zero.
- R12: Requests on consecutive cycles each produce their own result in consecutive cycles. No request is lost or merged with another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A demap store is present this cycle |
| req_addr | input | ADDR_W | Store address carrying the operation, context code, real flag and page |
| side_is_data | input | 1 | 1: data-side buffer, 0: instruction-side buffer |
| part_id | input | PART_W | Current partition register |
| ctx_primary | input | CTX_W | Primary context register |
| ctx_secondary | input | CTX_W | Secondary context register |
| cmd_valid | output | 1 | Single-cycle command pulse |
| cmd_kind | output | 2 | 0 page, 1 context, 2 partition-wide |
| cmd_page | output | ADDR_W-PAGE_LSB | Page address of a page command |
| cmd_real | output | 1 | Real-address flag of a page command |
| cmd_part | output | PART_W | Partition ID of the command |
| cmd_ctx | output | CTX_W | Context ID of the command |
| cmd_err | output | 1 | Single-cycle pulse for the reserved operation code |

## Verification
The assertions assume that the request inputs are stable around the sampling edge. They also assume that the context and partition registers, as seen at the edge where a request is taken, are the values the command must carry, so the checks compare against the past cycle's inputs. The stimulus changes every input only on the falling clock edge. It holds the context and partition values constant for the whole of each request. It sweeps every operation code, every context code and both sides against several page patterns, and it fills the address bits that must have no effect with non-zero values.

// File: rtl/demap_pkg.sv
package demap_pkg;

    // Address field positions the decode depends on
    localparam int CTX_FIELD_LSB = 4;
    localparam int OP_FIELD_LSB  = 6;
    localparam int REAL_BIT      = 9;

    typedef enum logic [1:0] {
        KIND_PAGE = 2'd0,
        KIND_CTX  = 2'd1,
        KIND_ALL  = 2'd2,
        KIND_BAD  = 2'd3
    } demap_kind_e;

    typedef enum logic [1:0] {
        CSEL_PRIMARY   = 2'd0,
        CSEL_SECONDARY = 2'd1,
        CSEL_NONE      = 2'd2,
        CSEL_NUCLEUS   = 2'd3
    } ctx_code_e;

    typedef struct packed {
        logic        issue;
        logic        error;
        demap_kind_e kind;
    } op_dec_t;

    function automatic demap_kind_e kind_of(input logic [7:0] low);
        return demap_kind_e'(low[OP_FIELD_LSB +: 2]);
    endfunction

    function automatic ctx_code_e ctx_code_of(input logic [7:0] low);
        return ctx_code_e'(low[CTX_FIELD_LSB +: 2]);
    endfunction

endpackage

// File: rtl/demap_ctx_sel.sv
module demap_ctx_sel
    import demap_pkg::*;
#(
    parameter int CTX_W = 13
) (
    input  ctx_code_e        code,
    input  logic             side_is_data,
    input  logic [CTX_W-1:0] ctx_primary,
    input  logic [CTX_W-1:0] ctx_secondary,
    output logic [CTX_W-1:0] ctx_id,
    output logic             ignored
);

    always_comb begin
        ctx_id  = '0;
        ignored = 1'b0;
        unique case (code)
            CSEL_PRIMARY: ctx_id = ctx_primary;
            CSEL_SECONDARY: begin
                // only the data side owns a secondary context
                if (side_is_data) ctx_id = ctx_secondary;
                else              ignored = 1'b1;
            end
            CSEL_NONE:    ignored = 1'b1;
            CSEL_NUCLEUS: ctx_id = '0;
            default:      ignored = 1'b1;
        endcase
    end

endmodule

// File: rtl/demap_op_decode.sv
module demap_op_decode
    import demap_pkg::*;
(
    input  demap_kind_e kind,
    input  logic        ignored,
    output op_dec_t     dec
);

    always_comb begin
        dec.kind  = kind;
        dec.issue = 1'b0;
        dec.error = 1'b0;
        unique case (kind)
            KIND_PAGE, KIND_CTX: dec.issue = !ignored;
            KIND_ALL:            dec.issue = 1'b1;   // partition-wide ignores the context code
            KIND_BAD:            dec.error = 1'b1;
            default:             dec.error = 1'b1;
        endcase
    end

endmodule

// File: rtl/demap_cmd_reg.sv
module demap_cmd_reg
    import demap_pkg::*;
#(
    parameter int PG_W   = 51,
    parameter int PART_W = 8,
    parameter int CTX_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  op_dec_t           dec,
    input  logic [PG_W-1:0]   page_in,
    input  logic              real_in,
    input  logic [PART_W-1:0] part_in,
    input  logic [CTX_W-1:0]  ctx_in,
    output logic              cmd_valid,
    output logic [1:0]        cmd_kind,
    output logic [PG_W-1:0]   cmd_page,
    output logic              cmd_real,
    output logic [PART_W-1:0] cmd_part,
    output logic [CTX_W-1:0]  cmd_ctx,
    output logic              cmd_err
);

    logic              nx_valid, nx_err, nx_real;
    logic [1:0]        nx_kind;
    logic [PG_W-1:0]   nx_page;
    logic [PART_W-1:0] nx_part;
    logic [CTX_W-1:0]  nx_ctx;

    always_comb begin
        nx_valid = req_valid && dec.issue;
        nx_err   = req_valid && dec.error;
        nx_kind  = '0;
        nx_page  = '0;
        nx_real  = 1'b0;
        nx_part  = '0;
        nx_ctx   = '0;
        if (nx_valid) begin
            nx_kind = dec.kind;
            nx_part = part_in;
            if (dec.kind != KIND_ALL) nx_ctx = ctx_in;
            if (dec.kind == KIND_PAGE) begin
                nx_page = page_in;
                nx_real = real_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid <= 1'b0;
            cmd_err   <= 1'b0;
            cmd_kind  <= '0;
            cmd_page  <= '0;
            cmd_real  <= 1'b0;
            cmd_part  <= '0;
            cmd_ctx   <= '0;
        end else begin
            cmd_valid <= nx_valid;
            cmd_err   <= nx_err;
            cmd_kind  <= nx_kind;
            cmd_page  <= nx_page;
            cmd_real  <= nx_real;
            cmd_part  <= nx_part;
            cmd_ctx   <= nx_ctx;
        end
    end

    // R11: data fields are quiet whenever no command is out
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> (cmd_kind == 2'd0 && cmd_page == '0 && !cmd_real
                        && cmd_part == '0 && cmd_ctx == '0));

    // R10: error and command never coincide
    a_r10_err_excl: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> !cmd_valid);

endmodule

// File: rtl/demap_decoder.sv
module demap_decoder
    import demap_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int PAGE_LSB = 13,   // must exceed REAL_BIT + 1
    parameter int PART_W   = 8,
    parameter int CTX_W    = 13
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     side_is_data,
    input  logic [PART_W-1:0]        part_id,
    input  logic [CTX_W-1:0]         ctx_primary,
    input  logic [CTX_W-1:0]         ctx_secondary,
    output logic                     cmd_valid,
    output logic [1:0]               cmd_kind,
    output logic [ADDR_W-PAGE_LSB-1:0] cmd_page,
    output logic                     cmd_real,
    output logic [PART_W-1:0]        cmd_part,
    output logic [CTX_W-1:0]         cmd_ctx,
    output logic                     cmd_err
);

    localparam int PG_W = ADDR_W - PAGE_LSB;

    ctx_code_e        code;
    demap_kind_e      kind;
    logic [CTX_W-1:0] sel_ctx;
    logic             sel_ignored;
    op_dec_t          dec;

    assign code = ctx_code_of(req_addr[7:0]);
    assign kind = kind_of(req_addr[7:0]);

    // bits that carry no meaning for a demap store
    logic unused_addr_bits;
    assign unused_addr_bits = ^{req_addr[PAGE_LSB-1:REAL_BIT+1], req_addr[8], req_addr[3:0]};

    demap_ctx_sel #(.CTX_W(CTX_W)) u_ctx_sel (
        .code          (code),
        .side_is_data  (side_is_data),
        .ctx_primary   (ctx_primary),
        .ctx_secondary (ctx_secondary),
        .ctx_id        (sel_ctx),
        .ignored       (sel_ignored)
    );

    demap_op_decode u_op_decode (
        .kind    (kind),
        .ignored (sel_ignored),
        .dec     (dec)
    );

    demap_cmd_reg #(.PG_W(PG_W), .PART_W(PART_W), .CTX_W(CTX_W)) u_cmd_reg (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .dec       (dec),
        .page_in   (req_addr[ADDR_W-1:PAGE_LSB]),
        .real_in   (req_addr[REAL_BIT]),
        .part_in   (part_id),
        .ctx_in    (sel_ctx),
        .cmd_valid (cmd_valid),
        .cmd_kind  (cmd_kind),
        .cmd_page  (cmd_page),
        .cmd_real  (cmd_real),
        .cmd_part  (cmd_part),
        .cmd_ctx   (cmd_ctx),
        .cmd_err   (cmd_err)
    );

    // R2: a command only ever follows a request
    a_r2_needs_request: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(req_valid));

    // R10: reserved operation code gives an error and no command
    a_r10_bad_op: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[7:6] == 2'd3) |=> (cmd_err && !cmd_valid));

    // R6: ignored page/context requests vanish
    a_r6_ignored_drop: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[7:6] < 2'd2 &&
         (req_addr[5:4] == 2'd2 || (req_addr[5:4] == 2'd1 && !side_is_data)))
        |=> (!cmd_valid && !cmd_err));

    // R7: partition-wide always goes out with context zero
    a_r7_all_issues: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[7:6] == 2'd2)
        |=> (cmd_valid && cmd_kind == 2'd2 && cmd_ctx == '0));

    // R8: page command carries the page and real flag of its request
    a_r8_page_fields: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd0)
        |-> (cmd_page == $past(req_addr[ADDR_W-1:PAGE_LSB]) &&
             cmd_real == $past(req_addr[REAL_BIT])));

    // R9: partition comes from the partition register
    a_r9_partition: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cmd_part == $past(part_id));

endmodule

// File: tb/test_demap_decoder.sv
module test_demap_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        side_is_data = 1'b0;
    logic [7:0]  part_id = '0;
    logic [12:0] ctx_primary = '0;
    logic [12:0] ctx_secondary = '0;
    logic        cmd_valid, cmd_real, cmd_err;
    logic [1:0]  cmd_kind;
    logic [50:0] cmd_page;
    logic [7:0]  cmd_part;
    logic [12:0] cmd_ctx;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;   // 125 MHz

    demap_decoder i_demap_decoder (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .side_is_data(side_is_data), .part_id(part_id),
        .ctx_primary(ctx_primary), .ctx_secondary(ctx_secondary),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_page(cmd_page),
        .cmd_real(cmd_real), .cmd_part(cmd_part), .cmd_ctx(cmd_ctx),
        .cmd_err(cmd_err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        logic [63:0] act;
        act = {cmd_valid, cmd_err, cmd_kind, cmd_real, cmd_part, cmd_ctx, 38'd0};
        chk(act == 64'd0 && cmd_page == '0, tag, "idle outputs", act, 64'd0);
    endtask

    // Drive one request at a falling edge, check its result one cycle later.
    task automatic do_req(input int op, input int code, input bit side,
                          input logic [50:0] pg, input bit rl,
                          input logic [12:0] pri, input logic [12:0] sec,
                          input logic [7:0] part);
        bit          ign, ev, ee;
        logic [12:0] ectx;
        logic [50:0] epg;
        bit          erl;
        string       tag;
        req_valid     = 1'b1;
        side_is_data  = side;
        ctx_primary   = pri;
        ctx_secondary = sec;
        part_id       = part;
        // junk in bits 12:10, 8 and 3:0 must not matter (R8)
        req_addr = {pg, 3'b101, rl, 1'b1, op[1:0], code[1:0], 4'hB};
        ign  = (code == 2) || (code == 1 && !side);
        ee   = (op == 3);
        ev   = !ee && (op == 2 || !ign);
        ectx = (!ev || op == 2) ? 13'd0 :
               (code == 0) ? pri : (code == 1) ? sec : 13'd0;
        epg  = (ev && op == 0) ? pg : '0;
        erl  = ev && op == 0 && rl;
        if (ee)                        tag = "R10";
        else if (ign && op < 2)        tag = (code == 2) ? "R5" : "R6";
        else if (op == 2)              tag = "R7";
        else if (code == 1)            tag = "R4";
        else                           tag = "R3";
        @(negedge clk);
        chk(cmd_valid == ev && cmd_err == ee, tag, "valid/err",
            {62'd0, cmd_valid, cmd_err}, {62'd0, ev, ee});
        chk(cmd_ctx == ectx, tag, "ctx", {51'd0, cmd_ctx}, {51'd0, ectx});
        chk(cmd_page == epg && cmd_real == erl, "R8", "page/real",
            {12'd0, cmd_real, cmd_page}, {12'd0, erl, epg});
        chk(cmd_part == (ev ? part : 8'd0), "R9", "partition",
            {56'd0, cmd_part}, {56'd0, (ev ? part : 8'd0)});
        chk(cmd_kind == (ev ? op[1:0] : 2'd0), "R2", "kind",
            {62'd0, cmd_kind}, {62'd0, (ev ? op[1:0] : 2'd0)});
    endtask

    initial begin
        // R1: reset holds outputs quiet even with a live request
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {51'h1_2345_6789_ABCD, 13'h0200};
        part_id   = 8'h77;
        @(negedge clk);
        check_idle("R1");
        @(negedge clk);
        check_idle("R1");
        rst = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        check_idle("R1");

        for (int side = 0; side < 2; side++) begin
            for (int op = 0; op < 4; op++) begin
                for (int code = 0; code < 4; code++) begin
                    for (int p = 0; p < 3; p++) begin
                        logic [50:0] pg;
                        pg = 51'h1_2345_6789_ABCD ^ (51'(p) * 51'h7_0F0F_0F0F_0F0F);
                        do_req(op, code, side[0], pg, p[0],
                               13'h1A5 + 13'(p), 13'h0F3 + 13'(p * 3),
                               8'h40 + 8'(op * 4 + code));
                    end
                end
            end
            // R2/R11: pulse lasts one cycle, outputs return to zero
            req_valid = 1'b0;
            @(negedge clk);
            check_idle("R11");
        end

        // R12: back-to-back requests keep their own results
        do_req(0, 0, 1'b1, 51'h7_FFFF_FFFF_FFFF, 1'b1, 13'h1FFF, 13'h0AAA, 8'hFF);
        do_req(1, 1, 1'b1, 51'h0_0000_0000_0001, 1'b0, 13'h0001, 13'h1555, 8'h01);
        chk(cmd_valid && cmd_ctx == 13'h1555, "R12", "second of burst",
            {50'd0, cmd_valid, cmd_ctx}, {50'd0, 1'b1, 13'h1555});
        do_req(3, 0, 1'b0, 51'h0, 1'b0, 13'h0, 13'h0, 8'h0);
        req_valid = 1'b0;
        @(negedge clk);
        check_idle("R10");

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule